// File: doc/BRIEF.md
# Dual-Clock Interprocessor Mailbox

This block lets two processors, called side A and side B, exchange messages although each runs on its own unrelated clock. Each side sees a small word-addressed register window with an address, write data, read data and single-cycle read and write strobes. Each side also has one interrupt line. In each direction there are four data channels, each carrying one 32-bit word at a time, and four doorbells that carry only an event.

A data word goes from the sender's transmit register to the same-numbered receive register on the other side. The sender's channel counts as busy until the receiver has read the word, so no word can be overwritten or dropped. Doorbells cross as toggles. The toggle is returned as an echo, so only one ring per bit is in flight. Rings made while one is in flight are merged into a single later toggle. The receiving side latches the event as a pending bit and clears it by writing 1 to that bit.

Each data channel is built from two state machines. The sender machine has the states TX_EMPTY, TX_REQ and TX_RELEASE:
- TX_EMPTY goes to TX_REQ on an accepted write.
- TX_REQ goes to TX_RELEASE when the synchronized acknowledge is seen high.
- TX_RELEASE goes back to TX_EMPTY when the acknowledge is seen low.

The receiver machine has the states RX_EMPTY, RX_FULL and RX_ACK:
- RX_EMPTY goes to RX_FULL when the synchronized request is seen, and the word is captured on that transition.
- RX_FULL goes to RX_ACK on a read of the receive register.
- RX_ACK goes back to RX_EMPTY when the request is seen low.

Every signal that crosses between the two clocks passes a two-flop synchronizer.

Top module: `xproc_mailbox`

Register map, the same on each side, by word address:

| Address | Register | Access |
|---|---|---|
| 0 to 3 | Transmit register of channel 0 to 3 | Write; reads back the held word |
| 4 to 7 | Receive register of channel 0 to 3 | Read |
| 8 | Status | Read; write 1 to clear pending bits |
| 9 | Ring | Write |
| 10 | Control | Read and write |

## Requirements
- R1: After reset, status (address 8) reads 0x0000000F, control (address 10) reads 0 and both interrupt lines are low. Status layout: bits [3:0] are transmit-empty per channel, bits [7:4] are receive-full per channel and bits [11:8] are doorbell-pending per channel.
- R2: A write to transmit register n (address n) while its empty bit is set clears that empty bit. Within 40 cycles of the slower clock, receive-full bit n of the peer is set.
- R3: Reading peer receive register n (address 4+n) returns the written word and clears its full bit. The sender's empty bit n then sets again within 40 cycles of the slower clock.
- R4: A write to a transmit register whose empty bit is clear is ignored. The register reads back the first word, the peer receives only the first word, and no second word follows.
- R5: A word sent on channel n sets only full bit n on the peer.
- R6: Writing a 1 to bit n of the ring register (address 9) sets pending bit n (status bit 8+n) on the peer within 40 cycles of the slower clock. The ringing side's own pending bits do not change.
- R7: Writing status with bit 8+n set clears pending bit n. Writing 0 to that bit leaves it set.
- R8: Rings of one doorbell on consecutive cycles are merged. The peer's pending bit sets, and after one clear it stays clear.
- R9: Control bits [3:0] enable transmit-empty interrupts, bits [7:4] enable receive-full interrupts and bits [11:8] enable doorbell interrupts. The interrupt line is high exactly when some enabled condition is set.
- R10: Control is read back unchanged at address 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Side A clock |
| rst_a_n | input | 1 | Side A asynchronous reset, active low |
| a_addr | input | 4 | Side A word address |
| a_wdata | input | 32 | Side A write data |
| a_wr | input | 1 | Side A write strobe |
| a_rd | input | 1 | Side A read strobe |
| a_rdata | output | 32 | Side A read data, combinational from address |
| a_irq | output | 1 | Side A interrupt |
| clk_b | input | 1 | Side B clock |
| rst_b_n | input | 1 | Side B asynchronous reset, active low |
| b_addr | input | 4 | Side B word address |
| b_wdata | input | 32 | Side B write data |
| b_wr | input | 1 | Side B write strobe |
| b_rd | input | 1 | Side B read strobe |
| b_rdata | output | 32 | Side B read data, combinational from address |
| b_irq | output | 1 | Side B interrupt |

## Verification
Each kind of faulty state shows up in the status flags within one round trip of the handshake:
- A sender machine stuck in TX_REQ or TX_RELEASE leaves its empty bit clear long after the peer has read the word.
- A receiver that captures at the wrong time returns a wrong word, or sets a full bit on the wrong channel.
- A lost or doubled doorbell toggle shows as a pending bit that never sets, or one that sets again after it was cleared.

Each of these faults is visible within a few tens of cycles of the slower clock. An interrupt mixing error shows on the same cycle that the control or status changes.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
    localparam int MB_NCH = 4;
    localparam int MB_DW  = 32;
    localparam int MB_AW  = 4;

    typedef enum logic [1:0] {
        TX_EMPTY   = 2'd0,
        TX_REQ     = 2'd1,
        TX_RELEASE = 2'd2
    } tx_state_t;

    typedef enum logic [1:0] {
        RX_EMPTY = 2'd0,
        RX_FULL  = 2'd1,
        RX_ACK   = 2'd2
    } rx_state_t;
endpackage

// File: rtl/mbox_sync.sv
module mbox_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/mbox_tx_chan.sv
module mbox_tx_chan
    import mbox_pkg::*;
#(
    parameter int DW = MB_DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] wdata,
    input  logic          ack_raw,
    output logic          req,
    output logic [DW-1:0] data,
    output logic          empty
);
    logic      ack_s;
    tx_state_t st_q, st_d;

    mbox_sync #(.W(1)) u_ack_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (ack_raw),
        .q    (ack_s)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= TX_EMPTY;
        else        st_q <= st_d;
    end

    // word is held from acceptance until the channel is empty again
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                         data <= '0;
        else if (load && st_q == TX_EMPTY)  data <= wdata;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            TX_EMPTY:   if (load)   st_d = TX_REQ;
            TX_REQ:     if (ack_s)  st_d = TX_RELEASE;
            TX_RELEASE: if (!ack_s) st_d = TX_EMPTY;
            default:                st_d = TX_EMPTY;
        endcase
    end

    always_comb begin
        req   = (st_q == TX_REQ);
        empty = (st_q == TX_EMPTY);
    end
endmodule

// File: rtl/mbox_rx_chan.sv
module mbox_rx_chan
    import mbox_pkg::*;
#(
    parameter int DW = MB_DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_en,
    input  logic          req_raw,
    input  logic [DW-1:0] data_in,
    output logic          ack,
    output logic          full,
    output logic [DW-1:0] data
);
    logic      req_s;
    rx_state_t st_q, st_d;

    mbox_sync #(.W(1)) u_req_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (req_raw),
        .q    (req_s)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RX_EMPTY;
        else        st_q <= st_d;
    end

    // sender holds data_in steady while its request is high
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          data <= '0;
        else if (st_q == RX_EMPTY && req_s)  data <= data_in;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            RX_EMPTY: if (req_s)  st_d = RX_FULL;
            RX_FULL:  if (rd_en)  st_d = RX_ACK;
            RX_ACK:   if (!req_s) st_d = RX_EMPTY;
            default:              st_d = RX_EMPTY;
        endcase
    end

    always_comb begin
        full = (st_q == RX_FULL);
        ack  = (st_q == RX_ACK);
    end
endmodule

// File: rtl/mbox_side.sv
module mbox_side
    import mbox_pkg::*;
#(
    parameter int NCH = MB_NCH,
    parameter int DW  = MB_DW,
    parameter int AW  = MB_AW
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [AW-1:0]           addr,
    input  logic [DW-1:0]           wdata,
    input  logic                    wr,
    input  logic                    rd,
    output logic [DW-1:0]           rdata,
    output logic                    irq,
    output logic [NCH-1:0]          tx_req,
    output logic [NCH-1:0][DW-1:0]  tx_data,
    input  logic [NCH-1:0]          tx_ack,
    input  logic [NCH-1:0]          rx_req,
    input  logic [NCH-1:0][DW-1:0]  rx_data_in,
    output logic [NCH-1:0]          rx_ack,
    output logic [NCH-1:0]          db_tgl,
    input  logic [NCH-1:0]          db_echo_in,
    input  logic [NCH-1:0]          peer_tgl,
    output logic [NCH-1:0]          db_echo
);
    localparam int ADR_RX   = NCH;
    localparam int ADR_STAT = 2 * NCH;
    localparam int ADR_RING = 2 * NCH + 1;
    localparam int ADR_CTRL = 2 * NCH + 2;
    localparam int CW       = 3 * NCH;

    logic [NCH-1:0]          tx_empty, rx_full, load, rd_en;
    logic [NCH-1:0][DW-1:0]  rx_word;
    logic [CW-1:0]           ctrl_q;
    logic [NCH-1:0]          pend_q, prev_q, ptgl_s, echo_s, queued_q;
    logic [NCH-1:0]          ring, clr, busy, fire, edge_seen;
    logic                    wr_stat, wr_ring, wr_ctrl;

    assign wr_stat = wr && (addr == AW'(ADR_STAT));
    assign wr_ring = wr && (addr == AW'(ADR_RING));
    assign wr_ctrl = wr && (addr == AW'(ADR_CTRL));

    for (genvar i = 0; i < NCH; i++) begin : g_chan
        assign load[i]  = wr && (addr == AW'(i));
        assign rd_en[i] = rd && (addr == AW'(ADR_RX + i));

        mbox_tx_chan #(.DW(DW)) u_tx (
            .clk    (clk),
            .rst_n  (rst_n),
            .load   (load[i]),
            .wdata  (wdata),
            .ack_raw(tx_ack[i]),
            .req    (tx_req[i]),
            .data   (tx_data[i]),
            .empty  (tx_empty[i])
        );

        mbox_rx_chan #(.DW(DW)) u_rx (
            .clk    (clk),
            .rst_n  (rst_n),
            .rd_en  (rd_en[i]),
            .req_raw(rx_req[i]),
            .data_in(rx_data_in[i]),
            .ack    (rx_ack[i]),
            .full   (rx_full[i]),
            .data   (rx_word[i])
        );
    end

    // doorbell sending: one toggle in flight per bit, later rings merged
    mbox_sync #(.W(NCH)) u_echo_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (db_echo_in),
        .q    (echo_s)
    );

    assign ring = wr_ring ? wdata[NCH-1:0] : '0;
    assign busy = db_tgl ^ echo_s;
    assign fire = ~busy & (ring | queued_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            db_tgl   <= '0;
            queued_q <= '0;
        end else begin
            db_tgl   <= db_tgl ^ fire;
            queued_q <= (queued_q | ring) & ~fire;
        end
    end

    // doorbell receiving: edge of the synchronized peer toggle
    mbox_sync #(.W(NCH)) u_tgl_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (peer_tgl),
        .q    (ptgl_s)
    );

    assign edge_seen = ptgl_s ^ prev_q;
    assign clr       = wr_stat ? wdata[CW-1:2*NCH] : '0;
    assign db_echo   = prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '0;
            pend_q <= '0;
        end else begin
            prev_q <= ptgl_s;
            pend_q <= (pend_q & ~clr) | edge_seen;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (wr_ctrl) ctrl_q <= wdata[CW-1:0];
    end

    assign irq = |(ctrl_q[NCH-1:0]     & tx_empty)
               | |(ctrl_q[2*NCH-1:NCH] & rx_full)
               | |(ctrl_q[CW-1:2*NCH]  & pend_q);

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NCH; i++) begin
            if (addr == AW'(i))          rdata = tx_data[i];
            if (addr == AW'(ADR_RX + i)) rdata = rx_word[i];
        end
        if (addr == AW'(ADR_STAT)) rdata = {{(DW-CW){1'b0}}, pend_q, rx_full, tx_empty};
        if (addr == AW'(ADR_CTRL)) rdata = {{(DW-CW){1'b0}}, ctrl_q};
    end
endmodule

// File: rtl/xproc_mailbox.sv
module xproc_mailbox
    import mbox_pkg::*;
#(
    parameter int NCH = MB_NCH,
    parameter int DW  = MB_DW,
    parameter int AW  = MB_AW
) (
    input  logic          clk_a,
    input  logic          rst_a_n,
    input  logic [AW-1:0] a_addr,
    input  logic [DW-1:0] a_wdata,
    input  logic          a_wr,
    input  logic          a_rd,
    output logic [DW-1:0] a_rdata,
    output logic          a_irq,
    input  logic          clk_b,
    input  logic          rst_b_n,
    input  logic [AW-1:0] b_addr,
    input  logic [DW-1:0] b_wdata,
    input  logic          b_wr,
    input  logic          b_rd,
    output logic [DW-1:0] b_rdata,
    output logic          b_irq
);
    logic [NCH-1:0]         a2b_req, a2b_ack, b2a_req, b2a_ack;
    logic [NCH-1:0][DW-1:0] a2b_data, b2a_data;
    logic [NCH-1:0]         a_db_tgl, b_db_tgl, a_db_echo, b_db_echo;

    mbox_side #(.NCH(NCH), .DW(DW), .AW(AW)) u_side_a (
        .clk       (clk_a),
        .rst_n     (rst_a_n),
        .addr      (a_addr),
        .wdata     (a_wdata),
        .wr        (a_wr),
        .rd        (a_rd),
        .rdata     (a_rdata),
        .irq       (a_irq),
        .tx_req    (a2b_req),
        .tx_data   (a2b_data),
        .tx_ack    (a2b_ack),
        .rx_req    (b2a_req),
        .rx_data_in(b2a_data),
        .rx_ack    (b2a_ack),
        .db_tgl    (a_db_tgl),
        .db_echo_in(b_db_echo),
        .peer_tgl  (b_db_tgl),
        .db_echo   (a_db_echo)
    );

    mbox_side #(.NCH(NCH), .DW(DW), .AW(AW)) u_side_b (
        .clk       (clk_b),
        .rst_n     (rst_b_n),
        .addr      (b_addr),
        .wdata     (b_wdata),
        .wr        (b_wr),
        .rd        (b_rd),
        .rdata     (b_rdata),
        .irq       (b_irq),
        .tx_req    (b2a_req),
        .tx_data   (b2a_data),
        .tx_ack    (b2a_ack),
        .rx_req    (a2b_req),
        .rx_data_in(a2b_data),
        .rx_ack    (a2b_ack),
        .db_tgl    (b_db_tgl),
        .db_echo_in(a_db_echo),
        .peer_tgl  (a_db_tgl),
        .db_echo   (b_db_echo)
    );
endmodule

// File: rtl/mbox_chk.sv
module mbox_chk #(
    parameter int NCH = 4,
    parameter int DW  = 32
) (
    input logic                   clk_a,
    input logic                   clk_b,
    input logic                   rst_a_n,
    input logic                   rst_b_n,
    input logic [NCH-1:0]         a2b_req,
    input logic [NCH-1:0]         a2b_ack,
    input logic [NCH-1:0][DW-1:0] a2b_data,
    input logic [NCH-1:0]         a_db_tgl,
    input logic [NCH-1:0]         b_db_echo
);
    for (genvar i = 0; i < NCH; i++) begin : g_chk
        // R4: the word offered to the peer holds while the request is up
        p_data_stable_r4: assert property (@(posedge clk_a) disable iff (!rst_a_n || !rst_b_n)
            (a2b_req[i] && $past(a2b_req[i])) |-> $stable(a2b_data[i]));

        // R3: the receiver acknowledges only a word that was requested
        p_ack_after_req_r3: assert property (@(posedge clk_b) disable iff (!rst_a_n || !rst_b_n)
            $rose(a2b_ack[i]) |-> $past(a2b_req[i]));

        // R2: the sender withdraws its request only after an acknowledge
        p_req_drop_after_ack_r2: assert property (@(posedge clk_a) disable iff (!rst_a_n || !rst_b_n)
            $fell(a2b_req[i]) |-> $past(a2b_ack[i]));

        // R8: a new doorbell toggle leaves only after the last one was echoed
        p_ring_one_inflight_r8: assert property (@(posedge clk_a) disable iff (!rst_a_n || !rst_b_n)
            (a_db_tgl[i] != $past(a_db_tgl[i])) |-> ($past(b_db_echo[i]) == $past(a_db_tgl[i])));
    end
endmodule

bind xproc_mailbox mbox_chk #(.NCH(NCH), .DW(DW)) u_chk (
    .clk_a    (clk_a),
    .clk_b    (clk_b),
    .rst_a_n  (rst_a_n),
    .rst_b_n  (rst_b_n),
    .a2b_req  (a2b_req),
    .a2b_ack  (a2b_ack),
    .a2b_data (a2b_data),
    .a_db_tgl (a_db_tgl),
    .b_db_echo(b_db_echo)
);

// File: tb/xproc_mailbox_tb.sv
`timescale 1ns/1ps
module xproc_mailbox_tb;
    logic        clk_a = 1'b0, clk_b = 1'b0;
    logic        rst_a_n = 1'b0, rst_b_n = 1'b0;
    logic [3:0]  a_addr = '0, b_addr = '0;
    logic [31:0] a_wdata = '0, b_wdata = '0;
    logic        a_wr = 1'b0, a_rd = 1'b0, b_wr = 1'b0, b_rd = 1'b0;
    logic [31:0] a_rdata, b_rdata;
    logic        a_irq, b_irq;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  done     = 1'b0;

    always #4   clk_a = ~clk_a;   // 125 MHz
    always #6.5 clk_b = ~clk_b;   // slower, unrelated side

    xproc_mailbox u_dut (
        .clk_a(clk_a), .rst_a_n(rst_a_n), .a_addr(a_addr), .a_wdata(a_wdata),
        .a_wr(a_wr), .a_rd(a_rd), .a_rdata(a_rdata), .a_irq(a_irq),
        .clk_b(clk_b), .rst_b_n(rst_b_n), .b_addr(b_addr), .b_wdata(b_wdata),
        .b_wr(b_wr), .b_rd(b_rd), .b_rdata(b_rdata), .b_irq(b_irq)
    );

    // {direction (0 = A to B), channel, word}
    localparam logic [34:0] VEC [0:7] = '{
        {1'b0, 2'd0, 32'hA5A5_0001},
        {1'b0, 2'd3, 32'hDEAD_BEEF},
        {1'b1, 2'd1, 32'h0000_0000},
        {1'b1, 2'd2, 32'hFFFF_FFFF},
        {1'b0, 2'd1, 32'h1234_5678},
        {1'b1, 2'd0, 32'h0BAD_F00D},
        {1'b1, 2'd3, 32'h8000_0001},
        {1'b0, 2'd2, 32'h0000_0000}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input bit side, input logic [3:0] ad, input logic [31:0] d);
        if (!side) begin
            @(negedge clk_a); a_addr = ad; a_wdata = d; a_wr = 1'b1;
            @(negedge clk_a); a_wr = 1'b0;
        end else begin
            @(negedge clk_b); b_addr = ad; b_wdata = d; b_wr = 1'b1;
            @(negedge clk_b); b_wr = 1'b0;
        end
    endtask

    task automatic bus_read(input bit side, input logic [3:0] ad, output logic [31:0] d);
        if (!side) begin
            @(negedge clk_a); a_addr = ad; a_rd = 1'b1; #1 d = a_rdata;
            @(negedge clk_a); a_rd = 1'b0;
        end else begin
            @(negedge clk_b); b_addr = ad; b_rd = 1'b1; #1 d = b_rdata;
            @(negedge clk_b); b_rd = 1'b0;
        end
    endtask

    task automatic settle(input int n);
        repeat (n) @(posedge clk_b);
    endtask

    initial begin
        repeat (150000) @(posedge clk_a);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        repeat (3) @(posedge clk_b);
        rst_a_n = 1'b1;
        rst_b_n = 1'b1;
        settle(2);

        // R1 reset state
        bus_read(1'b0, 4'd8, r);  check("R1 A status", r, 32'h0000_000F);
        bus_read(1'b1, 4'd8, r);  check("R1 B status", r, 32'h0000_000F);
        bus_read(1'b0, 4'd10, r); check("R1 A ctrl", r, 32'h0);
        check("R1 irqs", {30'b0, a_irq, b_irq}, 32'h0);

        // table of transfers in both directions
        for (int k = 0; k < 8; k++) begin
            bit          src;
            logic [1:0]  ch;
            logic [31:0] w;
            src = VEC[k][34];
            ch  = VEC[k][33:32];
            w   = VEC[k][31:0];
            bus_write(src, {2'b00, ch}, w);
            bus_read(src, 4'd8, r);
            check("R2 sender empty cleared", {28'b0, r[3:0]}, {28'b0, 4'hF & ~(4'h1 << ch)});
            settle(40);
            bus_read(~src, 4'd8, r);
            check("R5 only this channel full", {28'b0, r[7:4]}, {28'b0, 4'h1 << ch});
            bus_read(~src, 4'd4 + {2'b00, ch}, r);
            check("R3 received word", r, w);
            bus_read(~src, 4'd8, r);
            check("R3 full cleared by read", {28'b0, r[7:4]}, 32'h0);
            settle(40);
            bus_read(src, 4'd8, r);
            check("R3 sender empty again", {28'b0, r[3:0]}, 32'hF);
        end

        // R4 write while busy is ignored
        bus_write(1'b0, 4'd0, 32'h0000_0111);
        bus_write(1'b0, 4'd0, 32'h0000_0222);
        bus_read(1'b0, 4'd0, r);  check("R4 tx readback", r, 32'h0000_0111);
        settle(40);
        bus_read(1'b1, 4'd4, r);  check("R4 first word kept", r, 32'h0000_0111);
        settle(60);
        bus_read(1'b1, 4'd8, r);  check("R4 no second word", {28'b0, r[7:4]}, 32'h0);

        // R6 doorbell ring, R7 write-1-to-clear
        bus_write(1'b0, 4'd9, 32'h4);
        settle(40);
        bus_read(1'b1, 4'd8, r);  check("R6 peer pending", {28'b0, r[11:8]}, 32'h4);
        bus_read(1'b0, 4'd8, r);  check("R6 own pending untouched", {28'b0, r[11:8]}, 32'h0);
        bus_write(1'b1, 4'd8, 32'h0);
        bus_read(1'b1, 4'd8, r);  check("R7 zero write keeps pending", {28'b0, r[11:8]}, 32'h4);
        bus_write(1'b1, 4'd8, 32'h400);
        bus_read(1'b1, 4'd8, r);  check("R7 one write clears", {28'b0, r[11:8]}, 32'h0);

        // R8 back-to-back rings merge
        @(negedge clk_a); a_addr = 4'd9; a_wdata = 32'h1; a_wr = 1'b1;
        repeat (3) @(negedge clk_a);
        a_wr = 1'b0;
        settle(40);
        bus_read(1'b1, 4'd8, r);  check("R8 merged ring pending", {28'b0, r[11:8]}, 32'h1);
        bus_write(1'b1, 4'd8, 32'h100);
        settle(40);
        bus_read(1'b1, 4'd8, r);  check("R8 stays clear after merge", {28'b0, r[11:8]}, 32'h0);

        // R9 / R10 interrupt enables
        bus_write(1'b0, 4'd10, 32'h001);
        bus_read(1'b0, 4'd10, r); check("R10 ctrl readback", r, 32'h001);
        @(negedge clk_a);         check("R9 tx-empty irq", {31'b0, a_irq}, 32'h1);
        bus_write(1'b0, 4'd0, 32'h5555_AAAA);
        @(negedge clk_a);         check("R9 irq drops while busy", {31'b0, a_irq}, 32'h0);
        bus_write(1'b1, 4'd10, 32'h020);
        settle(40);
        check("R9 rx-full irq not enabled ch", {31'b0, b_irq}, 32'h0);
        bus_write(1'b0, 4'd1, 32'h0000_0042);
        settle(40);
        check("R9 rx-full irq", {31'b0, b_irq}, 32'h1);
        bus_read(1'b1, 4'd5, r);
        bus_read(1'b1, 4'd4, r);
        @(negedge clk_b);         check("R9 rx-full irq cleared", {31'b0, b_irq}, 32'h0);
        settle(40);
        @(negedge clk_a);         check("R9 tx-empty irq returns", {31'b0, a_irq}, 32'h1);
        bus_write(1'b0, 4'd10, 32'h0);
        @(negedge clk_a);         check("R9 irq disabled", {31'b0, a_irq}, 32'h0);
        bus_write(1'b1, 4'd10, 32'h400);
        bus_write(1'b0, 4'd9, 32'h4);
        settle(40);
        check("R9 doorbell irq", {31'b0, b_irq}, 32'h1);
        bus_write(1'b1, 4'd8, 32'h400);
        @(negedge clk_b);         check("R9 doorbell irq cleared", {31'b0, b_irq}, 32'h0);
        bus_read(1'b1, 4'd10, r); check("R10 B ctrl readback", r, 32'h400);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule